// File: doc/BRIEF.md
# I2C SCL Timing Generator

This block produces the serial-clock waveform and the data-hold strobe for a standard-mode I2C master. It takes two configuration words: the frequency of its own clock in hertz and the requested bus frequency in hertz. From them it derives a quarter-period divisor and checks that it lies in a legal window. It also picks an SDA hold count from the clock-rate band, and it packs the divisor into two control-byte images that sit beside an enable bit. A byte engine elsewhere uses the `sda_strobe` pulse as the moment to change SDA. It also watches `scl_out`, which is meant to drive an open-drain pad. The line as seen on the pad comes back in on `scl_in`, so a target that holds SCL low stretches the high phase.

The phase engine is a three-state machine. In IDLE, SCL is released and the counter is cleared. In LOW, SCL is driven low for twice the divisor, and the strobe fires at the hold count. In HIGH, SCL is released and the counter advances only on cycles where `scl_in` reads high. The transitions are IDLE to LOW on enable with a valid configuration, LOW to HIGH at the end of the low count, and HIGH to LOW at the end of the high count. Every state falls back to IDLE when the block is disabled or the configuration is in error.

Top module: `i2c_scl_timer`

## Requirements
- R1: During and after reset, `scl_out` is 1, `sda_strobe` is 0, `cfg_err` is 0 and both control bytes are 0.
- R2: The divisor is floor(`sys_clk_hz` / (4 × `bus_hz`)). When valid, `ctrl_lo[7:1]` holds divisor bits 6:0, `ctrl_hi[1:0]` holds divisor bits 8:7 and `ctrl_hi[7:2]` is 0. These values are due one clock after the configuration inputs change.
- R3: A divisor below 10 or above 511 sets `cfg_err`, clears both divisor fields and keeps `scl_out` at 1 even while `en` is high.
- R4: A `bus_hz` of 0 or above 100000 sets `cfg_err`, with the same effects as R3.
- R5: The hold count is 17 when `sys_clk_hz` ≥ 40000000, 15 when it is ≥ 12500000, and 7 otherwise.
- R6: `ctrl_lo[0]` follows `en` one clock later, and a divisor update never alters it.
- R7: With a valid configuration, raising `en` makes `scl_out` go low on the next clock. Each low phase lasts 2 × divisor cycles, and without stretching each high phase also lasts 2 × divisor cycles.
- R8: `sda_strobe` is a one-cycle pulse in the low phase, exactly hold-count cycles after `scl_out` falls (the first low cycle has index 0).
- R9: In the high phase, the counter advances only on cycles with `scl_in` high, so each stretched cycle extends the high phase by one cycle.
- R10: Dropping `en`, or a configuration error during a run, returns `scl_out` to 1 and stops the strobe. The next enable starts with a full low phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable |
| sys_clk_hz | input | 32 | System clock frequency in Hz |
| bus_hz | input | 32 | Requested SCL frequency in Hz |
| scl_in | input | 1 | Sampled SCL line level |
| scl_out | output | 1 | SCL drive (1 = released, 0 = pulled low) |
| sda_strobe | output | 1 | One-cycle pulse: SDA may change now |
| cfg_err | output | 1 | Configuration out of range |
| ctrl_lo | output | 8 | Divisor bits 6:0 in 7:1, enable in bit 0 |
| ctrl_hi | output | 8 | Divisor bits 8:7 in 1:0 |

## Verification
The configuration results (`cfg_err` and both control bytes) are registered once, so the bench sets the inputs at a falling edge and samples them at the very next falling edge. `scl_out` goes low one clock after `en` is seen high. From that first low sample, the bench predicts every later sample of `scl_out` and `sda_strobe` from the period 4 × divisor + stretch and the hold count. The bench drives stretch on the first high samples of each phase and compares each falling-edge sample against the prediction. A configuration error during a run is checked two samples later, because it passes through the configuration register and then the state register. A dropped enable is checked one sample later.

// File: rtl/i2c_scl_pkg.sv
package i2c_scl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2
    } scl_state_t;

endpackage

// File: rtl/i2c_scl_cfg.sv
module i2c_scl_cfg #(
    parameter int HZ_W        = 32,
    parameter int DIV_W       = 9,
    parameter int HOLD_W      = 5,
    parameter int DIV_MIN     = 10,
    parameter int DIV_MAX     = 511,
    parameter int MAX_BUS_HZ  = 100000,
    parameter int BAND_HI_HZ  = 40000000,
    parameter int BAND_MID_HZ = 12500000,
    parameter int HOLD_HI     = 17,
    parameter int HOLD_MID    = 15,
    parameter int HOLD_LO     = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [HZ_W-1:0]   sys_clk_hz,
    input  logic [HZ_W-1:0]   bus_hz,
    output logic [DIV_W-1:0]  div_q,
    output logic [HOLD_W-1:0] hold_q,
    output logic              err_q,
    output logic              en_q
);
    localparam int QW = HZ_W + 2;
    localparam logic [QW-1:0]     QMIN   = QW'(DIV_MIN);
    localparam logic [QW-1:0]     QMAX   = QW'(DIV_MAX);
    localparam logic [HZ_W-1:0]   BUSMAX = HZ_W'(MAX_BUS_HZ);
    localparam logic [HZ_W-1:0]   BHI    = HZ_W'(BAND_HI_HZ);
    localparam logic [HZ_W-1:0]   BMID   = HZ_W'(BAND_MID_HZ);

    logic [QW-1:0]     den;
    logic [QW-1:0]     quot;
    logic              bus_bad;
    logic              rng_bad;
    logic              err_d;
    logic [DIV_W-1:0]  div_d;
    logic [HOLD_W-1:0] hold_d;

    always_comb begin
        bus_bad = (bus_hz == '0) || (bus_hz > BUSMAX);
        den     = bus_bad ? QW'(4) : {bus_hz, 2'b00};
        quot    = {2'b00, sys_clk_hz} / den;
        rng_bad = (quot < QMIN) || (quot > QMAX);
        err_d   = bus_bad || rng_bad;
        div_d   = err_d ? '0 : quot[DIV_W-1:0];
        if (sys_clk_hz >= BHI)
            hold_d = HOLD_W'(HOLD_HI);
        else if (sys_clk_hz >= BMID)
            hold_d = HOLD_W'(HOLD_MID);
        else
            hold_d = HOLD_W'(HOLD_LO);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q  <= '0;
            hold_q <= '0;
            err_q  <= 1'b0;
            en_q   <= 1'b0;
        end else begin
            div_q  <= div_d;
            hold_q <= hold_d;
            err_q  <= err_d;
            en_q   <= en;
        end
    end

    // R4: an over-limit bus request is flagged on the next clock
    a_r4_bus_limit: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_hz > BUSMAX) |=> err_q);

    // R5: hold count is one of the three band values once loaded
    a_r5_hold_band: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_q != '0) |-> (hold_q == HOLD_W'(HOLD_HI) || hold_q == HOLD_W'(HOLD_MID)
                            || hold_q == HOLD_W'(HOLD_LO)));

    // R3: a non-zero stored divisor is always inside the legal window
    a_r3_div_window: assert property (@(posedge clk) disable iff (!rst_n)
        (div_q != '0) |-> (!err_q && div_q >= DIV_W'(DIV_MIN) && div_q <= DIV_W'(DIV_MAX)));

endmodule

// File: rtl/i2c_scl_phase.sv
module i2c_scl_phase
    import i2c_scl_pkg::*;
#(
    parameter int DIV_W  = 9,
    parameter int HOLD_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              cfg_err,
    input  logic [DIV_W-1:0]  div,
    input  logic [HOLD_W-1:0] hold,
    input  logic              scl_in,
    output logic              scl_out,
    output logic              sda_strobe
);
    localparam int CNT_W = DIV_W + 1;

    scl_state_t       state;
    scl_state_t       state_nx;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_nx;
    logic [CNT_W-1:0] half_lim;
    logic [CNT_W-1:0] hold_ext;
    logic             run_ok;
    logic             at_lim;

    assign half_lim = {div, 1'b0} - CNT_W'(1);
    assign hold_ext = {{(CNT_W-HOLD_W){1'b0}}, hold};
    assign run_ok   = en && !cfg_err;
    assign at_lim   = (cnt == half_lim);

    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        unique case (state)
            ST_IDLE: begin
                cnt_nx = '0;
                if (run_ok) state_nx = ST_LOW;
            end
            ST_LOW: begin
                if (!run_ok) begin
                    state_nx = ST_IDLE;
                    cnt_nx   = '0;
                end else if (at_lim) begin
                    state_nx = ST_HIGH;
                    cnt_nx   = '0;
                end else begin
                    cnt_nx = cnt + CNT_W'(1);
                end
            end
            ST_HIGH: begin
                if (!run_ok) begin
                    state_nx = ST_IDLE;
                    cnt_nx   = '0;
                end else if (scl_in) begin
                    if (at_lim) begin
                        state_nx = ST_LOW;
                        cnt_nx   = '0;
                    end else begin
                        cnt_nx = cnt + CNT_W'(1);
                    end
                end
            end
            default: begin
                state_nx = ST_IDLE;
                cnt_nx   = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= cnt_nx;
    end

    always_comb begin
        scl_out    = (state != ST_LOW);
        sda_strobe = (state == ST_LOW) && (cnt == hold_ext);
    end

    // R7: phase counter never runs past the half-period limit
    a_r7_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |-> (cnt <= half_lim));

    // R9: a low reading on the line stalls the high-phase count
    a_r9_stretch_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HIGH && !scl_in && run_ok) |=> (cnt == $past(cnt)));

    // R10: disabling returns the engine to idle with a cleared count
    a_r10_disable_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (scl_out && !sda_strobe && cnt == '0));

    // R3: a configuration error releases SCL on the next clock
    a_r3_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> scl_out);

endmodule

// File: rtl/i2c_scl_timer.sv
module i2c_scl_timer
    import i2c_scl_pkg::*;
#(
    parameter int HZ_W        = 32,
    parameter int DIV_W       = 9,
    parameter int HOLD_W      = 5,
    parameter int DIV_MIN     = 10,
    parameter int DIV_MAX     = 511,
    parameter int MAX_BUS_HZ  = 100000,
    parameter int BAND_HI_HZ  = 40000000,
    parameter int BAND_MID_HZ = 12500000,
    parameter int HOLD_HI     = 17,
    parameter int HOLD_MID    = 15,
    parameter int HOLD_LO     = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic [HZ_W-1:0] sys_clk_hz,
    input  logic [HZ_W-1:0] bus_hz,
    input  logic            scl_in,
    output logic            scl_out,
    output logic            sda_strobe,
    output logic            cfg_err,
    output logic [7:0]      ctrl_lo,
    output logic [7:0]      ctrl_hi
);
    localparam int LO_W = 7;
    localparam int HI_W = DIV_W - LO_W;

    logic [DIV_W-1:0]  div_q;
    logic [HOLD_W-1:0] hold_q;
    logic              err_q;
    logic              en_q;

    i2c_scl_cfg #(
        .HZ_W(HZ_W), .DIV_W(DIV_W), .HOLD_W(HOLD_W),
        .DIV_MIN(DIV_MIN), .DIV_MAX(DIV_MAX), .MAX_BUS_HZ(MAX_BUS_HZ),
        .BAND_HI_HZ(BAND_HI_HZ), .BAND_MID_HZ(BAND_MID_HZ),
        .HOLD_HI(HOLD_HI), .HOLD_MID(HOLD_MID), .HOLD_LO(HOLD_LO)
    ) cfg_i (
        .clk(clk), .rst_n(rst_n), .en(en),
        .sys_clk_hz(sys_clk_hz), .bus_hz(bus_hz),
        .div_q(div_q), .hold_q(hold_q), .err_q(err_q), .en_q(en_q)
    );

    i2c_scl_phase #(
        .DIV_W(DIV_W), .HOLD_W(HOLD_W)
    ) phase_i (
        .clk(clk), .rst_n(rst_n), .en(en), .cfg_err(err_q),
        .div(div_q), .hold(hold_q), .scl_in(scl_in),
        .scl_out(scl_out), .sda_strobe(sda_strobe)
    );

    assign cfg_err = err_q;
    assign ctrl_lo = {div_q[LO_W-1:0], en_q};
    assign ctrl_hi = {{(8-HI_W){1'b0}}, div_q[DIV_W-1:LO_W]};

endmodule

// File: tb/i2c_scl_timer_tb.sv
module i2c_scl_timer_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic [31:0] sys_clk_hz = 32'd4000000;
    logic [31:0] bus_hz = 32'd100000;
    logic        stretch = 1'b0;
    logic        scl_in;
    logic        scl_out, sda_strobe, cfg_err;
    logic [7:0]  ctrl_lo, ctrl_hi;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    assign scl_in = scl_out & ~stretch;

    i2c_scl_timer dut_i (
        .clk(clk), .rst_n(rst_n), .en(en),
        .sys_clk_hz(sys_clk_hz), .bus_hz(bus_hz), .scl_in(scl_in),
        .scl_out(scl_out), .sda_strobe(sda_strobe), .cfg_err(cfg_err),
        .ctrl_lo(ctrl_lo), .ctrl_hi(ctrl_hi)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic longint exp_div(input longint sys, input longint bus);
        if (bus == 0) return -1;
        return sys / (4 * bus);
    endfunction

    function automatic bit exp_err(input longint sys, input longint bus);
        longint d;
        d = exp_div(sys, bus);
        return (bus == 0) || (bus > 100000) || (d < 10) || (d > 511);
    endfunction

    function automatic int exp_hold(input longint sys);
        if (sys >= 40000000) return 17;
        if (sys >= 12500000) return 15;
        return 7;
    endfunction

    // drive configuration at a falling edge, check registered results one clock later
    task automatic check_cfg(input longint sys, input longint bus, output bit valid,
                             output int dv);
        bit  e;
        longint d;
        @(negedge clk);
        sys_clk_hz = 32'(sys);
        bus_hz = 32'(bus);
        @(negedge clk);
        e = exp_err(sys, bus);
        d = e ? 0 : exp_div(sys, bus);
        chk(cfg_err == e, (bus == 0 || bus > 100000) ? "R4" : "R3", "cfg_err", cfg_err, e);
        chk(ctrl_lo[7:1] == 7'(d & 127), "R2", "ctrl_lo[7:1]", ctrl_lo[7:1], d & 127);
        chk(ctrl_hi == 8'(d >> 7), "R2", "ctrl_hi", ctrl_hi, d >> 7);
        chk(ctrl_lo[0] == en, "R6", "ctrl_lo[0]", ctrl_lo[0], en);
        valid = !e;
        dv = int'(d);
    endtask

    // run the waveform from idle and compare every falling-edge sample
    task automatic run_wave(input int dv, input int hold, input int s, input int periods);
        int per, mism, hrun, t;
        bit es, et;
        logic [6:0] fld;
        per = 4 * dv + s;
        mism = 0;
        hrun = 0;
        @(negedge clk);
        en = 1'b1;
        stretch = 1'b0;
        for (int i = 0; i < per * periods + dv; i++) begin
            @(negedge clk);
            t = i % per;
            es = (t >= 2 * dv);
            et = (t == hold);
            if ((scl_out !== es || sda_strobe !== et) && mism == 0)
                $display("  first mismatch at sample %0d: scl %0b/%0b strobe %0b/%0b",
                         i, scl_out, es, sda_strobe, et);
            if (scl_out !== es || sda_strobe !== et) mism++;
            if (scl_out) begin
                stretch = (hrun < s);
                hrun++;
            end else begin
                hrun = 0;
                stretch = 1'b0;
            end
        end
        chk(mism == 0, s > 0 ? "R9" : "R7", "waveform mismatches", mism, 0);
        chk(ctrl_lo[0] == 1'b1, "R6", "enable bit while running", ctrl_lo[0], 1);
        fld = ctrl_lo[7:1];
        en = 1'b0;
        stretch = 1'b0;
        mism = 0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (scl_out !== 1'b1 || sda_strobe !== 1'b0) mism++;
        end
        chk(mism == 0, "R10", "disabled samples not idle", mism, 0);
        chk(ctrl_lo[0] == 1'b0, "R6", "enable bit after disable", ctrl_lo[0], 0);
        chk(ctrl_lo[7:1] == fld, "R6", "divisor field moved with enable", ctrl_lo[7:1], fld);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        bit v;
        int d, hold, s, seed;
        longint sys, bus;
        int mism;
        seed = $urandom(32'd2024);

        // R1: reset state
        repeat (3) @(negedge clk);
        chk(scl_out == 1'b1, "R1", "scl_out in reset", scl_out, 1);
        chk(sda_strobe == 1'b0, "R1", "sda_strobe in reset", sda_strobe, 0);
        chk(cfg_err == 1'b0, "R1", "cfg_err in reset", cfg_err, 0);
        chk(ctrl_lo == 8'h00 && ctrl_hi == 8'h00, "R1", "ctrl bytes in reset",
            {ctrl_hi, ctrl_lo}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(scl_out == 1'b1, "R1", "scl_out after reset", scl_out, 1);

        // R2/R3/R4: divisor window and bus limit boundaries
        check_cfg(4000000, 100000, v, d);
        chk(v && d == 10, "R3", "divisor 10 accepted", d, 10);
        check_cfg(3999999, 100000, v, d);
        check_cfg(204400000, 100000, v, d);
        chk(v && d == 511, "R3", "divisor 511 accepted", d, 511);
        check_cfg(204800000, 100000, v, d);
        check_cfg(100000000, 100001, v, d);
        check_cfg(100000000, 0, v, d);
        check_cfg(20000000, 40000, v, d);

        // R3: error configuration keeps SCL released with enable high
        check_cfg(100000000, 100001, v, d);
        en = 1'b1;
        mism = 0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (scl_out !== 1'b1 || sda_strobe !== 1'b0) mism++;
        end
        chk(mism == 0, "R4", "SCL moved under bad config", mism, 0);
        en = 1'b0;

        // R7/R8/R5: directed waveforms across hold bands
        check_cfg(4000000, 100000, v, d);
        run_wave(d, exp_hold(4000000), 0, 3);
        check_cfg(20000000, 100000, v, d);
        run_wave(d, exp_hold(20000000), 3, 2);
        check_cfg(48000000, 100000, v, d);
        run_wave(d, exp_hold(48000000), 0, 2);
        // R5: band edges
        check_cfg(40000000, 100000, v, d);
        run_wave(d, 17, 0, 1);
        check_cfg(39999999, 100000, v, d);
        run_wave(d, 15, 0, 1);
        check_cfg(12500000, 100000, v, d);
        run_wave(d, 15, 0, 1);
        check_cfg(12499999, 100000, v, d);
        run_wave(d, 7, 1, 1);
        check_cfg(204400000, 100000, v, d);
        run_wave(d, 17, 2, 1);

        // R10: configuration error in mid-run releases SCL two samples later
        check_cfg(4000000, 100000, v, d);
        @(negedge clk);
        en = 1'b1;
        repeat (5) @(negedge clk);
        bus_hz = 32'd0;
        @(negedge clk);
        mism = 0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            if (scl_out !== 1'b1 || sda_strobe !== 1'b0) mism++;
        end
        chk(mism == 0, "R10", "SCL not released after mid-run error", mism, 0);
        en = 1'b0;

        // random configurations
        for (int k = 0; k < 40; k++) begin
            sys = 100000 + longint'($urandom % 80000000);
            bus = 10000 + longint'($urandom % 100000);
            check_cfg(sys, bus, v, d);
            if (v && d <= 80) begin
                s = int'($urandom % 5);
                hold = exp_hold(sys);
                run_wave(d, hold, s, 2);
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule